// File: doc/BRIEF.md
# SPI Status and Error Flag Unit

This block holds the status side of an 8-bit serial peripheral. It sits between the CPU register strobes and the serial shift engine. From the engine it takes a transfer-active level, a byte-complete pulse that carries the received byte, and a mode-fault pulse. It keeps four flags: transfer done, write collision, overrun and mode fault. It also holds the control register, the receive buffer and the interrupt request.

No flag is cleared by writing to it. Each flag goes back to zero only after its own ordered pair of register accesses. A two-step pair is tracked by an armed bit, which the first access sets. Any other CPU access in between drops the armed bit. Idle cycles keep it. When an overrun occurs, the receive buffer keeps the first unread byte and drops every byte that arrives after it. While a mode fault is pending, control writes cannot turn the enable or master bits back on.

The CPU issues at most one register access (status read, data read, data write, control write) per cycle. The flags are presented on `sts_o` as {done, wcol, ovr, modf}, bit 3 down to bit 0.

Top module: `spi_flag_unit`

## Requirements
- R1: A data write while `xfer_busy_i` is high is discarded: `tx_load_o` stays low, and the write-collision flag (`sts_o[2]`) is set one cycle later. A data write while idle drives `tx_load_o` high in the same cycle, with `tx_data_o` equal to the written byte.
- R2: The write-collision flag never raises `irq_o`.
- R3: A `byte_done_i` pulse sets the done flag (`sts_o[3]`) on the next cycle. If done was clear, the pulse also loads `rx_byte_i` into `rx_data_o`.
- R4: A status read taken while done is set, followed by a data read, clears both done and write-collision. Idle cycles between the two reads are allowed.
- R5: A data read followed by a status read clears write-collision.
- R6: A data write never clears write-collision.
- R7: A `byte_done_i` pulse while done is set, and not cleared in that same cycle, sets overrun (`sts_o[1]`). In that case `rx_data_o` keeps the byte it already held. If the clearing data read and a new byte come in the same cycle, the new byte is loaded and no overrun is flagged.
- R8: Any status read clears overrun.
- R9: A `mode_fault_i` pulse sets the mode-fault flag (`sts_o[0]`) and clears control bits 6 (enable) and 4 (master).
- R10: A status read taken while mode-fault is set, followed by a control write, clears mode-fault. That control write is applied in full.
- R11: While mode-fault is set, any other control write is applied with bits 6 and 4 unable to become 1. The other bits are written normally.
- R12: `irq_o` equals control bit 7 (interrupt enable) AND (done OR overrun OR mode-fault).
- R13: A different register access between the two steps of a clearing pair disarms it, so the flag stays set.
- R14: After reset, all flags, the control register and the receive buffer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | CTRL_W | Control write data |
| sts_rd_i | input | 1 | Status register read strobe |
| dat_rd_i | input | 1 | Data register read strobe |
| dat_wr_i | input | 1 | Data register write strobe |
| dat_wdata_i | input | DATA_W | Data write byte |
| xfer_busy_i | input | 1 | Engine transfer in progress |
| byte_done_i | input | 1 | Engine byte complete pulse |
| rx_byte_i | input | DATA_W | Byte received with byte_done_i |
| mode_fault_i | input | 1 | Engine mode-fault detect pulse |
| ctl_o | output | CTRL_W | Control register contents |
| sts_o | output | 4 | Flags {done, wcol, ovr, modf} |
| rx_data_o | output | DATA_W | Receive buffer |
| tx_load_o | output | 1 | Accepted data write to engine |
| tx_data_o | output | DATA_W | Byte handed to engine |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit data, an 8-bit control register, and interrupt enable, SPI enable and master on bits 7, 6 and 4. With these values every control byte and every received byte in the vector table decodes directly. It also puts the lockout mask on a known pair of bits, so partially blocked writes such as 0xD5 turning into 0x85 can be predicted exactly. The table covers the clearing pairs with idle gaps and with intervening accesses, three byte completions in a row, and a clearing read that lands in the same cycle as a new byte.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int STS_W = 4;

    typedef struct packed {
        logic done;
        logic wcol;
        logic ovr;
        logic modf;
    } flags_t;

    typedef struct packed {
        logic done;
        logic wcol;
        logic modf;
    } arm_t;

endpackage

// File: rtl/spif_flags.sv
module spif_flags
    import spi_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sts_rd,
    input  logic   dat_rd,
    input  logic   dat_wr,
    input  logic   ctl_wr,
    input  logic   busy,
    input  logic   byte_done,
    input  logic   mode_fault,
    output flags_t flags_o,
    output logic   load_rx_o,
    output logic   tx_accept_o,
    output logic   modf_release_o
);

    typedef struct packed {
        flags_t f;
        arm_t   arm;
    } state_t;

    state_t s_d, s_q;
    logic   any_acc;
    logic   done_clr;
    logic   wcol_clr;
    logic   modf_clr;
    logic   overrun_hit;

    always_comb begin
        s_d         = s_q;
        any_acc     = sts_rd | dat_rd | dat_wr | ctl_wr;
        done_clr    = dat_rd & s_q.arm.done;
        wcol_clr    = done_clr | (sts_rd & s_q.arm.wcol);
        modf_clr    = ctl_wr & s_q.arm.modf;
        overrun_hit = byte_done & s_q.f.done & ~done_clr;

        // every access restarts the pair trackers; idle cycles keep them
        if (any_acc) begin
            s_d.arm.done = sts_rd & s_q.f.done;
            s_d.arm.wcol = dat_rd;
            s_d.arm.modf = sts_rd & s_q.f.modf;
        end

        // set terms win over clear terms in the same cycle
        s_d.f.done = byte_done | (s_q.f.done & ~done_clr);
        s_d.f.wcol = (dat_wr & busy) | (s_q.f.wcol & ~wcol_clr);
        s_d.f.ovr  = overrun_hit | (s_q.f.ovr & ~sts_rd);
        s_d.f.modf = mode_fault | (s_q.f.modf & ~modf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o        = s_q.f;
    assign load_rx_o      = byte_done & ~overrun_hit;
    assign tx_accept_o    = dat_wr & ~busy;
    assign modf_release_o = modf_clr;

endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl #(
    parameter int CTRL_W = 8,
    parameter int EN_BIT = 6,
    parameter int MS_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              modf_set,
    input  logic              modf_release,
    input  logic              mode_fault,
    output logic [CTRL_W-1:0] ctl_o
);

    typedef struct packed {
        logic [CTRL_W-1:0] reg_v;
    } state_t;

    state_t            s_d, s_q;
    logic [CTRL_W-1:0] wval;

    always_comb begin
        s_d  = s_q;
        wval = wdata;
        // pending fault: enable and master may be cleared but not set
        if (modf_set && !modf_release) begin
            wval[EN_BIT] = wdata[EN_BIT] & s_q.reg_v[EN_BIT];
            wval[MS_BIT] = wdata[MS_BIT] & s_q.reg_v[MS_BIT];
        end
        if (ctl_wr) s_d.reg_v = wval;
        if (mode_fault) begin
            s_d.reg_v[EN_BIT] = 1'b0;
            s_d.reg_v[MS_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o = s_q.reg_v;

endmodule

// File: rtl/spif_rxbuf.sv
module spif_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] byte_in,
    output logic [DATA_W-1:0] byte_o
);

    typedef struct packed {
        logic [DATA_W-1:0] held;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) s_d.held = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_o = s_q.held;

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
    import spi_flag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 8,
    parameter int IE_BIT = 7,
    parameter int EN_BIT = 6,
    parameter int MS_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic [CTRL_W-1:0] ctl_wdata_i,
    input  logic              sts_rd_i,
    input  logic              dat_rd_i,
    input  logic              dat_wr_i,
    input  logic [DATA_W-1:0] dat_wdata_i,
    input  logic              xfer_busy_i,
    input  logic              byte_done_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              mode_fault_i,
    output logic [CTRL_W-1:0] ctl_o,
    output logic [STS_W-1:0]  sts_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              tx_load_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              irq_o
);

    flags_t flags;
    logic   load_rx;
    logic   modf_release;

    spif_flags u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .sts_rd         (sts_rd_i),
        .dat_rd         (dat_rd_i),
        .dat_wr         (dat_wr_i),
        .ctl_wr         (ctl_wr_i),
        .busy           (xfer_busy_i),
        .byte_done      (byte_done_i),
        .mode_fault     (mode_fault_i),
        .flags_o        (flags),
        .load_rx_o      (load_rx),
        .tx_accept_o    (tx_load_o),
        .modf_release_o (modf_release)
    );

    spif_ctrl #(
        .CTRL_W (CTRL_W),
        .EN_BIT (EN_BIT),
        .MS_BIT (MS_BIT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr_i),
        .wdata        (ctl_wdata_i),
        .modf_set     (flags.modf),
        .modf_release (modf_release),
        .mode_fault   (mode_fault_i),
        .ctl_o        (ctl_o)
    );

    spif_rxbuf #(
        .DATA_W (DATA_W)
    ) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_rx),
        .byte_in (rx_byte_i),
        .byte_o  (rx_data_o)
    );

    assign sts_o     = flags;
    assign tx_data_o = dat_wdata_i;
    assign irq_o     = ctl_o[IE_BIT] & (flags.done | flags.ovr | flags.modf);

endmodule

// File: rtl/spi_flag_unit_chk.sv
module spi_flag_unit_chk #(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 8,
    parameter int IE_BIT = 7,
    parameter int EN_BIT = 6,
    parameter int MS_BIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr_i,
    input logic              sts_rd_i,
    input logic              dat_rd_i,
    input logic              dat_wr_i,
    input logic              xfer_busy_i,
    input logic              byte_done_i,
    input logic              mode_fault_i,
    input logic [CTRL_W-1:0] ctl_o,
    input logic [3:0]        sts_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              tx_load_o,
    input logic              irq_o
);

    a_r1_busy_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_i && xfer_busy_i) |=> sts_o[2]);

    a_r1_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_i && xfer_busy_i) |-> !tx_load_o);

    a_r3_byte_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_i |=> sts_o[3]);

    a_r4_done_clears_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o[3]) |-> $past(dat_rd_i));

    a_r6_wcol_clear_by_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o[2]) |-> ($past(dat_rd_i) || $past(sts_rd_i)));

    a_r7_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_i && sts_o[3] && !dat_rd_i) |=> sts_o[1]);

    a_r7_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_i && sts_o[3] && !dat_rd_i) |=> $stable(rx_data_o));

    a_r8_overrun_clears_on_status: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o[1]) |-> $past(sts_rd_i));

    a_r9_fault_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault_i |=> (sts_o[0] && !ctl_o[EN_BIT] && !ctl_o[MS_BIT]));

    a_r10_fault_clears_on_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o[0]) |-> $past(ctl_wr_i));

    a_r11_lockout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o[0] |-> (!ctl_o[EN_BIT] && !ctl_o[MS_BIT]));

    a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[IE_BIT] |-> !irq_o);

endmodule

bind spi_flag_unit spi_flag_unit_chk #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .IE_BIT (IE_BIT),
    .EN_BIT (EN_BIT),
    .MS_BIT (MS_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr_i     (ctl_wr_i),
    .sts_rd_i     (sts_rd_i),
    .dat_rd_i     (dat_rd_i),
    .dat_wr_i     (dat_wr_i),
    .xfer_busy_i  (xfer_busy_i),
    .byte_done_i  (byte_done_i),
    .mode_fault_i (mode_fault_i),
    .ctl_o        (ctl_o),
    .sts_o        (sts_o),
    .rx_data_o    (rx_data_o),
    .tx_load_o    (tx_load_o),
    .irq_o        (irq_o)
);

// File: tb/spi_flag_unit_test.sv
module spi_flag_unit_test;

    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0, sts_rd = 1'b0, dat_rd = 1'b0, dat_wr = 1'b0;
    logic [CW-1:0] ctl_wdata = '0;
    logic [DW-1:0] dat_wdata = '0, rx_byte = '0;
    logic          busy = 1'b0, bdone = 1'b0, mfault = 1'b0;
    logic [CW-1:0] ctl;
    logic [3:0]    sts;
    logic [DW-1:0] rxd, txd;
    logic          txl, irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    spi_flag_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_i     (ctl_wr),
        .ctl_wdata_i  (ctl_wdata),
        .sts_rd_i     (sts_rd),
        .dat_rd_i     (dat_rd),
        .dat_wr_i     (dat_wr),
        .dat_wdata_i  (dat_wdata),
        .xfer_busy_i  (busy),
        .byte_done_i  (bdone),
        .rx_byte_i    (rx_byte),
        .mode_fault_i (mfault),
        .ctl_o        (ctl),
        .sts_o        (sts),
        .rx_data_o    (rxd),
        .tx_load_o    (txl),
        .tx_data_o    (txd),
        .irq_o        (irq)
    );

    // op: 0 idle, 1 status read, 2 data read, 3 data write, 4 control write
    typedef struct packed {
        logic [2:0]    op;
        logic [7:0]    d;
        logic          busy;
        logic          bd;
        logic          mf;
        logic [3:0]    e_sts;
        logic [7:0]    e_rx;
        logic [7:0]    e_ctl;
        logic          e_irq;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{3'd4, 8'hD0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h00, 8'hD0, 1'b0}, // 0 R12 setup
        '{3'd3, 8'h11, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h00, 8'hD0, 1'b0}, // 1 R1 R2
        '{3'd0, 8'hA5, 1'b0, 1'b1, 1'b0, 4'b1100, 8'hA5, 8'hD0, 1'b1}, // 2 R3
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1100, 8'hA5, 8'hD0, 1'b1}, // 3 R4 step 1
        '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 8'hA5, 8'hD0, 1'b0}, // 4 R4 step 2
        '{3'd0, 8'h3C, 1'b0, 1'b1, 1'b0, 4'b1000, 8'h3C, 8'hD0, 1'b1}, // 5 R3
        '{3'd0, 8'h77, 1'b0, 1'b1, 1'b0, 4'b1010, 8'h3C, 8'hD0, 1'b1}, // 6 R7
        '{3'd0, 8'h88, 1'b0, 1'b1, 1'b0, 4'b1010, 8'h3C, 8'hD0, 1'b1}, // 7 R7
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h3C, 8'hD0, 1'b1}, // 8 R8
        '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h3C, 8'hD0, 1'b0}, // 9 R4
        '{3'd3, 8'h22, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 10 R1 R2
        '{3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 11 R5 step 1
        '{3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 12 R5 idle gap
        '{3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0000, 8'h3C, 8'hD0, 1'b0}, // 13 R5 step 2
        '{3'd3, 8'h33, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 14 R1
        '{3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 15 R13 arm
        '{3'd3, 8'h44, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 16 R6 no clear
        '{3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 17 R13 disarmed
        '{3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0100, 8'h3C, 8'hD0, 1'b0}, // 18 R5
        '{3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 4'b0000, 8'h3C, 8'hD0, 1'b0}, // 19 R5
        '{3'd0, 8'h5A, 1'b0, 1'b1, 1'b0, 4'b1000, 8'h5A, 8'hD0, 1'b1}, // 20 R3
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h5A, 8'hD0, 1'b1}, // 21 R13 arm
        '{3'd3, 8'h66, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h5A, 8'hD0, 1'b1}, // 22 R13 disarm
        '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h5A, 8'hD0, 1'b1}, // 23 R13 stays
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h5A, 8'hD0, 1'b1}, // 24 R4
        '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h5A, 8'hD0, 1'b0}, // 25 R4
        '{3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 4'b0001, 8'h5A, 8'h80, 1'b1}, // 26 R9
        '{3'd4, 8'hD5, 1'b0, 1'b0, 1'b0, 4'b0001, 8'h5A, 8'h85, 1'b1}, // 27 R11
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0001, 8'h5A, 8'h85, 1'b1}, // 28 R10 arm
        '{3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0001, 8'h5A, 8'h85, 1'b1}, // 29 R13 disarm
        '{3'd4, 8'hD0, 1'b0, 1'b0, 1'b0, 4'b0001, 8'h5A, 8'h80, 1'b1}, // 30 R11
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0001, 8'h5A, 8'h80, 1'b1}, // 31 R10 arm
        '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 4'b0001, 8'h5A, 8'h80, 1'b1}, // 32 R10 idle gap
        '{3'd4, 8'hD0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h5A, 8'hD0, 1'b0}, // 33 R10
        '{3'd4, 8'h50, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h5A, 8'h50, 1'b0}, // 34 R12
        '{3'd0, 8'h99, 1'b0, 1'b1, 1'b0, 4'b1000, 8'h99, 8'h50, 1'b0}, // 35 R12
        '{3'd0, 8'h12, 1'b0, 1'b1, 1'b0, 4'b1010, 8'h99, 8'h50, 1'b0}, // 36 R7 R12
        '{3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h99, 8'h50, 1'b0}, // 37 R8
        '{3'd2, 8'h42, 1'b0, 1'b1, 1'b0, 4'b1000, 8'h42, 8'h50, 1'b0}  // 38 R7 same-cycle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ctl_wr = 1'b0; sts_rd = 1'b0; dat_rd = 1'b0; dat_wr = 1'b0;
        bdone = 1'b0; mfault = 1'b0; busy = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        check("R14 reset", {sts, rxd, ctl, 7'd0, irq}, 32'h0);

        // R1 idle write is passed through combinationally
        dat_wr = 1'b1; dat_wdata = 8'hC3; busy = 1'b0;
        #1;
        check("R1 idle load", {23'd0, txl, txd}, {23'd0, 1'b1, 8'hC3});
        busy = 1'b1;
        #1;
        check("R1 busy drop", {31'd0, txl}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check("R1 busy write flag", {28'd0, sts}, 32'h4);
        // R6 write while idle does not clear the flag
        dat_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check("R6 idle write", {28'd0, sts}, 32'h4);
        // return to reset for the table
        rst_n = 1'b0;
        @(negedge clk);
        check("R14 re-reset", {sts, rxd, ctl, 7'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            ctl_wr    = (VECS[i].op == 3'd4);
            sts_rd    = (VECS[i].op == 3'd1);
            dat_rd    = (VECS[i].op == 3'd2);
            dat_wr    = (VECS[i].op == 3'd3);
            ctl_wdata = VECS[i].d;
            dat_wdata = VECS[i].d;
            rx_byte   = VECS[i].d;
            busy      = VECS[i].busy;
            bdone     = VECS[i].bd;
            mfault    = VECS[i].mf;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            if ({sts, rxd, ctl, irq} !== {VECS[i].e_sts, VECS[i].e_rx, VECS[i].e_ctl, VECS[i].e_irq}) begin
                fails++;
                $display("FAIL vector %0d (see table tag): actual sts=%b rx=%h ctl=%h irq=%b expected sts=%b rx=%h ctl=%h irq=%b",
                         i, sts, rxd, ctl, irq,
                         VECS[i].e_sts, VECS[i].e_rx, VECS[i].e_ctl, VECS[i].e_irq);
            end
            checks++;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule